// File: doc/BRIEF.md
# Nibble-Wide CRC-5 Engine

This block keeps a running 5-bit cyclic redundancy check over a stream that arrives four bits per clock. A bit-serial shift register would need four clocks for each nibble. Here, one combinational XOR network folds the whole nibble into the state in a single cycle. The generator polynomial is x^5 + x^2 + 1, written as 0x05 once the top term is dropped.

Each of the five next-state bits is the parity of a fixed subset of the current state bits and the nibble bits. The subsets are not written out by hand. At elaboration time the serial update is evaluated once for every one-hot state value (with the data held at zero) and once for every one-hot nibble (with the state held at zero). A bit takes part in an output's equation exactly when its one-hot result has a 1 in that output's position. Superposition then combines the two contributions.

The state is synchronously reset to all ones. Software-facing framing is left to the surrounding logic, and so is any final inversion of the result.

Top module: `crc5_nibble_gen`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, `crc_out` becomes 5'b11111 after that edge, whatever `data_vld` and `data_nib` are.
- R2: When `rst_n` is high and `data_vld` is low at an edge, `crc_out` keeps its value after that edge.
- R3: When `rst_n` and `data_vld` are high at an edge, `crc_out` after the edge equals four serial steps applied to its previous value. The steps consume `data_nib` bit 0 first, then bit 1, bit 2 and bit 3. One serial step computes f = crc[4] XOR d, shifts the state left by one with a 0 entering bit 0, and XORs in 5'b00101 when f is 1.
- R4: A zero state that absorbs a zero nibble stays zero.
- R5: Superposition holds. The update from state S with nibble D equals the update from S with nibble 0, XOR the update from state 0 with nibble D.
- R6: All 512 combinations of a 5-bit state and a 4-bit nibble give the R3 result, each in a single clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the all-ones state |
| data_vld | input | 1 | High when `data_nib` carries a nibble to absorb |
| data_nib | input | 4 | Data nibble; bit 0 is absorbed first |
| crc_out | output | 5 | Current CRC state |

## Verification
The bench builds the block with its default parameters: a 5-bit state, a 4-bit nibble and polynomial 0x05. With these values the full space has only 32 states times 16 nibbles. A long stream of pseudo-random nibbles, with gaps in `data_vld`, therefore reaches every state/nibble pair, and the bench confirms that coverage. Each nibble is also applied singly from reset to check superposition against a nibble-0 run. The stream is then steered into the zero state, to show that zero input keeps it there.

// File: rtl/crc5n_pkg.sv
// Package crc5n_pkg
// Holds the default configuration of the nibble CRC engine, plus the
// elaboration-time helpers that derive its XOR taps from the serial update.
// Assumes widths of at most 32 bits.
package crc5n_pkg;

    localparam int          CRC_W_DEF = 5;
    localparam int          DAT_W_DEF = 4;
    localparam logic [31:0] POLY_DEF  = 32'h0000_0005;
    localparam logic [31:0] INIT_DEF  = 32'h0000_001F;

    // Serial reference: advance state st by dw data bits, LSB of dat first.
    function automatic logic [31:0] lfsr_advance(
        input logic [31:0] st,
        input logic [31:0] dat,
        input int          cw,
        input int          dw,
        input logic [31:0] poly
    );
        logic [31:0] s;
        logic [31:0] msk;
        logic        fb;
        msk = (32'h1 << cw) - 32'h1;
        s   = st & msk;
        for (int b = 0; b < dw; b++) begin
            fb = s[cw-1] ^ dat[b];
            s  = ((s << 1) & msk) ^ (fb ? (poly & msk) : 32'h0);
        end
        return s;
    endfunction

    // Tap mask for output bit j: bit i is set when one-hot input i
    // (state side or data side) reaches output j.
    function automatic logic [31:0] tap_mask(
        input int          j,
        input bit          from_state,
        input int          cw,
        input int          dw,
        input logic [31:0] poly
    );
        logic [31:0] m;
        logic [31:0] r;
        int          n;
        m = 32'h0;
        n = from_state ? cw : dw;
        for (int i = 0; i < n; i++) begin
            if (from_state)
                r = lfsr_advance(32'h1 << i, 32'h0, cw, dw, poly);
            else
                r = lfsr_advance(32'h0, 32'h1 << i, cw, dw, poly);
            m[i] = r[j];
        end
        return m;
    endfunction

endpackage

// File: rtl/crc_xor_net.sv
// Module crc_xor_net
// Combinational next-state network. Each output bit is the parity of the
// current-state bits and data bits selected by masks computed at elaboration.
// Assumes CW and DW are each at most 32.
module crc_xor_net
    import crc5n_pkg::*;
#(
    parameter int          CW   = CRC_W_DEF,
    parameter int          DW   = DAT_W_DEF,
    parameter logic [31:0] POLY = POLY_DEF
) (
    input  logic [CW-1:0] cur,
    input  logic [DW-1:0] din,
    output logic [CW-1:0] nxt
);

    // One parity tree per output bit.
    for (genvar j = 0; j < CW; j++) begin : g_out
        localparam logic [31:0] SMASK = tap_mask(j, 1'b1, CW, DW, POLY);
        localparam logic [31:0] DMASK = tap_mask(j, 1'b0, CW, DW, POLY);

        logic s_par;
        logic d_par;

        // Parity of the state bits feeding output j.
        assign s_par  = ^(cur & SMASK[CW-1:0]);
        // Parity of the data bits feeding output j.
        assign d_par  = ^(din & DMASK[DW-1:0]);
        // Superposition of the two contributions.
        assign nxt[j] = s_par ^ d_par;
    end

endmodule

// File: rtl/crc_state_reg.sv
// Module crc_state_reg
// CRC state register. It loads the init value under synchronous active-low
// reset, takes the next state when load is high, and holds otherwise.
module crc_state_reg #(
    parameter int            CW   = 5,
    parameter logic [CW-1:0] INIT = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] nxt,
    output logic [CW-1:0] q
);

    // State update: reset has priority, then load, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= INIT;
        else if (load)
            q <= nxt;
    end

endmodule

// File: rtl/crc5_nibble_gen.sv
// Module crc5_nibble_gen
// Running CRC over DAT_W bits per clock (default: 5-bit CRC, polynomial 0x05,
// nibble input, LSB first). Framing and output inversion are left to the user.
module crc5_nibble_gen
    import crc5n_pkg::*;
#(
    parameter int          CRC_W = CRC_W_DEF,
    parameter int          DAT_W = DAT_W_DEF,
    parameter logic [31:0] POLY  = POLY_DEF,
    parameter logic [31:0] INIT  = INIT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_vld,
    input  logic [DAT_W-1:0] data_nib,
    output logic [CRC_W-1:0] crc_out
);

    localparam logic [CRC_W-1:0] INIT_V = INIT[CRC_W-1:0];

    logic [CRC_W-1:0] nxt_state;

    // Next state from the elaborated XOR network.
    crc_xor_net #(
        .CW   (CRC_W),
        .DW   (DAT_W),
        .POLY (POLY)
    ) i_net (
        .cur (crc_out),
        .din (data_nib),
        .nxt (nxt_state)
    );

    // State storage.
    crc_state_reg #(
        .CW   (CRC_W),
        .INIT (INIT_V)
    ) i_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (data_vld),
        .nxt   (nxt_state),
        .q     (crc_out)
    );

endmodule

// File: rtl/crc5_nibble_chk.sv
// Module crc5_nibble_chk
// Property checker for crc5_nibble_gen, attached with bind. It keeps its own
// bit-serial step, written separately from the tap derivation.
module crc5_nibble_chk #(
    parameter int          CW   = 5,
    parameter int          DW   = 4,
    parameter logic [31:0] POLY = 32'h5,
    parameter logic [31:0] INIT = 32'h1F
) (
    input logic          clk,
    input logic          rst_n,
    input logic          data_vld,
    input logic [DW-1:0] data_nib,
    input logic [CW-1:0] crc_out
);

    // Bit-serial reference over one full input word.
    function automatic logic [CW-1:0] serial_word(input logic [CW-1:0] s, input logic [DW-1:0] d);
        logic [CW-1:0] v;
        v = s;
        for (int b = 0; b < DW; b++) begin
            if (v[CW-1] != d[b])
                v = {v[CW-2:0], 1'b0} ^ POLY[CW-1:0];
            else
                v = {v[CW-2:0], 1'b0};
        end
        return v;
    endfunction

    // R1
    reset_init_chk: assert property (@(posedge clk)
        !rst_n |=> crc_out == INIT[CW-1:0]);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_vld |=> $stable(crc_out));

    // R3
    word_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_vld |=> crc_out == serial_word($past(crc_out), $past(data_nib)));

    // R4
    zero_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld && data_nib == '0 && crc_out == '0) |=> crc_out == '0);

endmodule

bind crc5_nibble_gen crc5_nibble_chk #(
    .CW   (CRC_W),
    .DW   (DAT_W),
    .POLY (POLY),
    .INIT (INIT)
) i_crc5_nibble_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_vld (data_vld),
    .data_nib (data_nib),
    .crc_out  (crc_out)
);

// File: tb/test_crc5_nibble_gen.sv
// Bench test_crc5_nibble_gen
// Sweeps the default configuration against a bit-serial model.
module test_crc5_nibble_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_vld = 1'b0;
    logic [3:0] data_nib = 4'h0;
    logic [4:0] crc_out;

    int n_chk = 0;
    int n_bad = 0;
    bit cov [0:511];

    crc5_nibble_gen i_crc5_nibble_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_vld (data_vld),
        .data_nib (data_nib),
        .crc_out  (crc_out)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Serial model: bit 0 first, f = msb ^ d, shift left, xor 5'b00101 on f.
    function automatic logic [4:0] model(input logic [4:0] s, input logic [3:0] d);
        logic [4:0] v;
        logic       f;
        v = s;
        for (int b = 0; b < 4; b++) begin
            f = v[4] ^ d[b];
            v = {v[3:0], 1'b0};
            if (f) v = v ^ 5'b00101;
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, then wait one full cycle to the next falling edge.
    task automatic cyc(input logic r, input logic v, input logic [3:0] d);
        rst_n    = r;
        data_vld = v;
        data_nib = d;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [4:0] exp;
        logic [4:0] a;
        logic [4:0] b;
        int         missing;
        @(negedge clk);
        cyc(1'b0, 1'b0, 4'h0);
        // R1 reset state
        check("R1", crc_out, 5'h1F);

        // R1 reset wins over a valid nibble
        cyc(1'b1, 1'b1, 4'h9);
        cyc(1'b0, 1'b1, 4'h6);
        check("R1", crc_out, 5'h1F);

        // R3 and R5: each nibble from reset, compared with the nibble-0 run
        for (int d = 0; d < 16; d++) begin
            cyc(1'b0, 1'b0, 4'h0);
            cyc(1'b1, 1'b1, d[3:0]);
            a = crc_out;
            check("R3", a, model(5'h1F, d[3:0]));
            cyc(1'b0, 1'b0, 4'h0);
            cyc(1'b1, 1'b1, 4'h0);
            b = crc_out;
            check("R5", a ^ b, model(5'h00, d[3:0]));
        end

        // R2 and R6: long stream with gaps, pair coverage
        cyc(1'b0, 1'b0, 4'h0);
        exp = 5'h1F;
        for (int k = 0; k < 20000; k++) begin
            logic       v;
            logic [3:0] d;
            v = ($urandom_range(0, 3) != 0);
            d = 4'($urandom_range(0, 15));
            if (v) cov[{exp, d}] = 1'b1;
            cyc(1'b1, v, d);
            if (v) begin
                exp = model(exp, d);
                check("R6", crc_out, exp);
            end else begin
                check("R2", crc_out, exp);
            end
        end
        missing = 0;
        for (int p = 0; p < 512; p++) if (!cov[p]) missing++;
        check("R6", 5'(missing), 5'd0);

        // R4: steer into the zero state, then feed zero nibbles
        for (int k = 0; k < 500 && exp != 5'h00; k++) begin
            logic [3:0] d;
            d = 4'($urandom_range(0, 15));
            for (int c = 0; c < 16; c++)
                if (model(exp, c[3:0]) == 5'h00) d = c[3:0];
            cyc(1'b1, 1'b1, d);
            exp = model(exp, d);
        end
        check("R4", crc_out, 5'h00);
        for (int k = 0; k < 3; k++) begin
            cyc(1'b1, 1'b1, 4'h0);
            check("R4", crc_out, 5'h00);
        end

        // R2: a hold gap with a changing nibble
        cyc(1'b1, 1'b1, 4'hA);
        exp = model(5'h00, 4'hA);
        cyc(1'b1, 1'b0, 4'h5);
        cyc(1'b1, 1'b0, 4'hF);
        check("R2", crc_out, exp);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule